// File: doc/BRIEF.md
# Frame-Indexed Address Translation Scanner

This block translates a virtual address for one process. It walks a table that holds one entry per physical frame. Each entry names the owner process, the virtual page it holds, and a set of info bits. The block reads the entries through a synchronous memory read port, one per cycle, starting at entry 0. The first entry whose owner and page number both equal the request's, and whose valid flag is set, ends the walk. The index of that entry becomes the physical frame number. If every frame is examined and none matches, the block reports a page fault.

A requester presents a process ID and a 64-bit virtual address while `ready_o` is high. The block takes the request on that clock edge and scans until it hits or runs out of frames. It then pulses `done_o` for one cycle, together with either `hit_o` and a physical address or `fault_o`. The table memory sits outside the block and returns read data one cycle after the read strobe. The number of frames is a parameter, so a 512 MB memory of 4 KB pages uses 2^17 frames.

Top module: `ipt_walker`

## Requirements
- R1: `ready_o` is high only when no walk is in progress. A request is taken on a rising edge where `req_valid_i` and `ready_o` are both high. `ready_o` is low from the next cycle until the walk ends, and requests presented during a walk have no effect on its result.
- R2: A walk issues exactly one read per cycle on `rd_en_o`/`rd_addr_o`. The first read goes to address 0, in the cycle after acceptance, and each later read goes to the next consecutive address.
- R3: A table word holds the owner process ID in bits [79:64], the virtual page number in bits [63:12] and the info bits in [11:0], with the valid flag at bit 0. An entry matches only when its process ID and page number both equal the request's and its valid flag is 1.
- R4: When several entries match, the one with the lowest index is reported.
- R5: On a hit, `pa_o` equals the matching index concatenated with the request's low 12 address bits, which pass through unchanged.
- R6: If all FRAMES entries are examined without a match, the walk ends with `fault_o`.
- R7: For a hit at index k, `done_o` is high in the cycle that starts k+2 rising edges after acceptance. A fault completes FRAMES+1 edges after acceptance.
- R8: `done_o` is a one-cycle pulse. With it, exactly one of `hit_o` and `fault_o` is high, and both are low whenever `done_o` is low.
- R9: `pa_o` changes only when a hit completes. A fault, or the cycles between completions, leave it holding its previous value.
- R10: An active-low asynchronous reset aborts any walk and leaves `ready_o` high with `done_o`, `hit_o`, `fault_o`, `rd_en_o` low and `pa_o` zero.
- R11: No read is issued while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request present |
| req_pid_i | input | PID_W (16) | Requesting process ID |
| req_va_i | input | VPN_W+OFF_W (64) | Virtual address to translate |
| ready_o | output | 1 | Block idle, request can be taken |
| rd_en_o | output | 1 | Table read strobe |
| rd_addr_o | output | clog2(FRAMES) | Table entry index being read |
| rd_data_i | input | PID_W+VPN_W+INFO_W (80) | Entry returned one cycle after the strobe |
| done_o | output | 1 | Walk finished, one-cycle pulse |
| hit_o | output | 1 | Walk found a matching entry |
| fault_o | output | 1 | Walk found no match |
| pa_o | output | clog2(FRAMES)+OFF_W | Physical address of the last hit |

## Verification
Every walk's outcome has a fixed timing. A hit at index k completes k+2 edges after the accepting edge, and a fault completes FRAMES+1 edges after it. The bench therefore counts rising edges from acceptance and samples each falling edge until `done_o`. It then compares the count against the expected value derived from the table it loaded. During the same walk it checks, at each falling edge, that the read address advances by one from zero and that the number of reads equals min(k+2, FRAMES). One falling edge after completion, it checks that `done_o` has dropped and that `pa_o` still holds its value.

// File: rtl/ipt_pkg.sv
package ipt_pkg;
  localparam int unsigned DEF_PID_W  = 16;
  localparam int unsigned DEF_VPN_W  = 52;
  localparam int unsigned DEF_INFO_W = 12;
  localparam int unsigned DEF_OFF_W  = 12;
  localparam int unsigned DEF_FRAMES = 1 << 17;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } scan_st_e;
endpackage

// File: rtl/ipt_entry_cmp.sv
module ipt_entry_cmp #(
  parameter int unsigned PID_W  = 16,
  parameter int unsigned VPN_W  = 52,
  parameter int unsigned INFO_W = 12,
  parameter logic [INFO_W-1:0] INFO_MASK = 1,
  parameter logic [INFO_W-1:0] INFO_VAL  = 1,
  localparam int unsigned ENT_W = PID_W + VPN_W + INFO_W
) (
  input  logic [ENT_W-1:0] entry_i,
  input  logic [PID_W-1:0] pid_i,
  input  logic [VPN_W-1:0] vpn_i,
  output logic             match_o
);
  localparam int unsigned INFO_LO = 0;
  localparam int unsigned VPN_LO  = INFO_W;
  localparam int unsigned PID_LO  = INFO_W + VPN_W;

  logic [PID_W-1:0]  ent_pid;
  logic [VPN_W-1:0]  ent_vpn;
  logic [INFO_W-1:0] ent_info;
  logic              pid_eq, vpn_eq, info_ok;

  assign ent_pid  = entry_i[PID_LO +: PID_W];
  assign ent_vpn  = entry_i[VPN_LO +: VPN_W];
  assign ent_info = entry_i[INFO_LO +: INFO_W];

  assign pid_eq  = (ent_pid == pid_i);
  assign vpn_eq  = (ent_vpn == vpn_i);
  // info bits selected by the mask must equal the required pattern (valid flag by default)
  assign info_ok = ((ent_info & INFO_MASK) == (INFO_VAL & INFO_MASK));

  assign match_o = pid_eq && vpn_eq && info_ok;
endmodule

// File: rtl/ipt_scan_ctrl.sv
module ipt_scan_ctrl
  import ipt_pkg::*;
#(
  parameter int unsigned FRAMES = 8,
  localparam int unsigned PFN_W = (FRAMES > 1) ? $clog2(FRAMES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             match_i,
  output logic             busy_o,
  output logic             rd_en_o,
  output logic [PFN_W-1:0] rd_addr_o,
  output logic             finish_o,
  output logic             finish_hit_o,
  output logic [PFN_W-1:0] finish_idx_o
);
  localparam logic [PFN_W-1:0] LAST_IDX = PFN_W'(FRAMES - 1);

  scan_st_e         st_q;
  logic             issue_q;
  logic [PFN_W-1:0] idx_q;
  logic             cmp_vld_q;
  logic [PFN_W-1:0] cmp_idx_q;
  logic             last_cmp;

  assign last_cmp     = (cmp_idx_q == LAST_IDX);
  assign finish_o     = cmp_vld_q && (match_i || last_cmp);
  assign finish_hit_o = cmp_vld_q && match_i;
  assign finish_idx_o = cmp_idx_q;

  assign busy_o    = (st_q == ST_SCAN);
  assign rd_en_o   = issue_q;
  assign rd_addr_o = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      issue_q   <= 1'b0;
      idx_q     <= '0;
      cmp_vld_q <= 1'b0;
      cmp_idx_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          cmp_vld_q <= 1'b0;
          if (start_i) begin
            st_q    <= ST_SCAN;
            issue_q <= 1'b1;
            idx_q   <= '0;
          end
        end
        ST_SCAN: begin
          // read data returns one cycle after the strobe: compare stage trails issue by one
          cmp_vld_q <= issue_q && !finish_o;
          cmp_idx_q <= idx_q;
          if (issue_q) begin
            if (idx_q == LAST_IDX) issue_q <= 1'b0;
            else                   idx_q   <= PFN_W'(idx_q + 1'b1);
          end
          if (finish_o) begin
            st_q    <= ST_IDLE;
            issue_q <= 1'b0;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ipt_resp_reg.sv
module ipt_resp_reg #(
  parameter int unsigned PFN_W = 3,
  parameter int unsigned OFF_W = 12,
  localparam int unsigned PA_W = PFN_W + OFF_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             finish_i,
  input  logic             hit_i,
  input  logic [PFN_W-1:0] pfn_i,
  input  logic [OFF_W-1:0] off_i,
  output logic             done_o,
  output logic             hit_o,
  output logic             fault_o,
  output logic [PA_W-1:0]  pa_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o  <= 1'b0;
      hit_o   <= 1'b0;
      fault_o <= 1'b0;
      pa_o    <= '0;
    end else begin
      done_o  <= finish_i;
      hit_o   <= finish_i && hit_i;
      fault_o <= finish_i && !hit_i;
      if (finish_i && hit_i) pa_o <= {pfn_i, off_i};
    end
  end
endmodule

// File: rtl/ipt_walker.sv
module ipt_walker
  import ipt_pkg::*;
#(
  parameter int unsigned FRAMES = DEF_FRAMES,
  parameter int unsigned PID_W  = DEF_PID_W,
  parameter int unsigned VPN_W  = DEF_VPN_W,
  parameter int unsigned INFO_W = DEF_INFO_W,
  parameter int unsigned OFF_W  = DEF_OFF_W,
  parameter logic [INFO_W-1:0] INFO_MASK = 1,
  parameter logic [INFO_W-1:0] INFO_VAL  = 1,
  localparam int unsigned PFN_W = (FRAMES > 1) ? $clog2(FRAMES) : 1,
  localparam int unsigned VA_W  = VPN_W + OFF_W,
  localparam int unsigned PA_W  = PFN_W + OFF_W,
  localparam int unsigned ENT_W = PID_W + VPN_W + INFO_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [PID_W-1:0] req_pid_i,
  input  logic [VA_W-1:0]  req_va_i,
  output logic             ready_o,
  output logic             rd_en_o,
  output logic [PFN_W-1:0] rd_addr_o,
  input  logic [ENT_W-1:0] rd_data_i,
  output logic             done_o,
  output logic             hit_o,
  output logic             fault_o,
  output logic [PA_W-1:0]  pa_o
);
  logic             busy;
  logic             accept;
  logic             match;
  logic             finish;
  logic             finish_hit;
  logic [PFN_W-1:0] finish_idx;

  logic [PID_W-1:0] pid_q;
  logic [VPN_W-1:0] vpn_q;
  logic [OFF_W-1:0] off_q;

  assign ready_o = !busy;
  assign accept  = req_valid_i && ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pid_q <= '0;
      vpn_q <= '0;
      off_q <= '0;
    end else if (accept) begin
      pid_q <= req_pid_i;
      vpn_q <= req_va_i[OFF_W +: VPN_W];
      off_q <= req_va_i[OFF_W-1:0];
    end
  end

  ipt_entry_cmp #(
    .PID_W(PID_W), .VPN_W(VPN_W), .INFO_W(INFO_W),
    .INFO_MASK(INFO_MASK), .INFO_VAL(INFO_VAL)
  ) u_cmp (
    .entry_i (rd_data_i),
    .pid_i   (pid_q),
    .vpn_i   (vpn_q),
    .match_o (match)
  );

  ipt_scan_ctrl #(.FRAMES(FRAMES)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (accept),
    .match_i      (match),
    .busy_o       (busy),
    .rd_en_o      (rd_en_o),
    .rd_addr_o    (rd_addr_o),
    .finish_o     (finish),
    .finish_hit_o (finish_hit),
    .finish_idx_o (finish_idx)
  );

  ipt_resp_reg #(.PFN_W(PFN_W), .OFF_W(OFF_W)) u_resp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .finish_i (finish),
    .hit_i    (finish_hit),
    .pfn_i    (finish_idx),
    .off_i    (off_q),
    .done_o   (done_o),
    .hit_o    (hit_o),
    .fault_o  (fault_o),
    .pa_o     (pa_o)
  );
endmodule

// File: rtl/ipt_walker_chk.sv
module ipt_walker_chk #(
  parameter int unsigned PFN_W = 3,
  parameter int unsigned PA_W  = 15
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             ready_o,
  input logic             rd_en_o,
  input logic [PFN_W-1:0] rd_addr_o,
  input logic             done_o,
  input logic             hit_o,
  input logic             fault_o,
  input logic [PA_W-1:0]  pa_o
);
  a_r1_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && ready_o) |=> !ready_o);

  a_r2_first_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_en_o) |-> (rd_addr_o == '0));

  a_r2_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_o && $past(rd_en_o)) |-> (rd_addr_o == PFN_W'($past(rd_addr_o) + 1'b1)));

  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r8_one_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $onehot({hit_o, fault_o}));

  a_r8_quiet_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> !(hit_o || fault_o));

  a_r9_pa_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> $stable(pa_o));

  a_r11_idle_no_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !rd_en_o);
endmodule

bind ipt_walker ipt_walker_chk #(.PFN_W(PFN_W), .PA_W(PA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .ready_o     (ready_o),
  .rd_en_o     (rd_en_o),
  .rd_addr_o   (rd_addr_o),
  .done_o      (done_o),
  .hit_o       (hit_o),
  .fault_o     (fault_o),
  .pa_o        (pa_o)
);

// File: tb/ipt_walker_test.sv
`timescale 1ns/1ps
module ipt_walker_test;
  localparam int unsigned FRAMES = 8;
  localparam int unsigned PFN_W  = 3;
  localparam int unsigned PA_W   = PFN_W + 12;
  localparam int unsigned NV     = 8;

  typedef struct packed {
    logic [15:0] pid;
    logic [51:0] vpn;
    logic [11:0] off;
    logic        hit;
    logic [2:0]  pfn;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{16'h0001, 52'h100, 12'h345, 1'b1, 3'd0},             // R3 plain hit
    '{16'h0002, 52'h100, 12'h000, 1'b1, 3'd1},             // R3 pid distinguishes
    '{16'h0001, 52'h200, 12'hFFF, 1'b1, 3'd4},             // R3 invalid entry 2 skipped
    '{16'h0003, 52'hABC, 12'h001, 1'b1, 3'd3},             // R4 dup at 3 and 5
    '{16'h0007, 52'hF_FFFF_FFFF_FFFF, 12'h800, 1'b1, 3'd7}, // last frame
    '{16'h0009, 52'h100, 12'h123, 1'b0, 3'd0},             // R6 fault
    '{16'h0003, 52'h100, 12'h456, 1'b0, 3'd0},             // R6 vpn only
    '{16'h0000, 52'h000, 12'h789, 1'b0, 3'd0}              // R3 empty frame not hit
  };

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             req_valid_i = 1'b0;
  logic [15:0]      req_pid_i = '0;
  logic [63:0]      req_va_i = '0;
  logic             ready_o, rd_en_o, done_o, hit_o, fault_o;
  logic [PFN_W-1:0] rd_addr_o;
  logic [79:0]      rd_data_i;
  logic [PA_W-1:0]  pa_o;
  logic [79:0]      mem [FRAMES];

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;
  logic [PA_W-1:0] last_pa = '0;

  always #2 clk = ~clk;

  always_ff @(posedge clk) if (rd_en_o) rd_data_i <= mem[rd_addr_o];

  ipt_walker #(.FRAMES(FRAMES)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
    .req_pid_i(req_pid_i), .req_va_i(req_va_i), .ready_o(ready_o),
    .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
    .done_o(done_o), .hit_o(hit_o), .fault_o(fault_o), .pa_o(pa_o)
  );

  function automatic logic [79:0] ent(input logic [15:0] p, input logic [51:0] v, input logic vld);
    return {p, v, 11'h0A5, vld};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // one walk; checks R1 R2 R5 R6 R7 R8 R9
  task automatic walk(input logic [15:0] pid, input logic [51:0] vpn, input logic [11:0] off,
                      input bit exp_hit, input int k, input bit hold_req);
    int cnt = 0;
    int reads = 0;
    int exp_lat, exp_reads;
    bit addr_ok = 1;
    logic [PA_W-1:0] pa_before;
    pa_before = pa_o;
    check(ready_o === 1'b1, "R1 ready before request", 64'(ready_o), 64'd1);
    req_valid_i = 1'b1;
    req_pid_i   = pid;
    req_va_i    = {vpn, off};
    @(posedge clk);
    @(negedge clk);
    if (hold_req) begin
      req_pid_i = 16'h0003;
      req_va_i  = {52'hABC, 12'h001};
    end else req_valid_i = 1'b0;
    check(ready_o === 1'b0, "R1 busy after accept", 64'(ready_o), 64'd0);
    while (!done_o) begin
      if (rd_en_o) begin
        if (rd_addr_o != PFN_W'(reads)) addr_ok = 0;
        reads++;
      end
      @(negedge clk);
      cnt++;
    end
    req_valid_i = 1'b0;
    if (rd_en_o) reads++;
    exp_lat   = exp_hit ? k + 2 : FRAMES + 1;
    exp_reads = exp_hit ? ((k + 2 < FRAMES) ? k + 2 : FRAMES) : FRAMES;
    check(addr_ok, "R2 read addresses ascend from 0", 64'(addr_ok), 64'd1);
    check(reads == exp_reads, "R2 read count", 64'(reads), 64'(exp_reads));
    check(cnt == exp_lat, "R7 completion latency", 64'(cnt), 64'(exp_lat));
    check(hit_o === exp_hit, "R3/R4/R6 hit flag", 64'(hit_o), 64'(exp_hit));
    check(fault_o === !exp_hit, "R6/R8 fault flag", 64'(fault_o), 64'(!exp_hit));
    if (exp_hit) begin
      check(pa_o === {PFN_W'(k), off}, "R5 physical address", 64'(pa_o), 64'({PFN_W'(k), off}));
      last_pa = pa_o;
    end else begin
      check(pa_o === pa_before, "R9 fault leaves pa", 64'(pa_o), 64'(pa_before));
    end
    @(negedge clk);
    check(done_o === 1'b0 && hit_o === 1'b0 && fault_o === 1'b0, "R8 done one cycle",
          64'({done_o, hit_o, fault_o}), 64'd0);
    check(pa_o === last_pa, "R9 pa holds", 64'(pa_o), 64'(last_pa));
    check(rd_en_o === 1'b0, "R11 no read when idle", 64'(rd_en_o), 64'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < FRAMES; i++) mem[i] = '0;
    mem[0] = ent(16'h0001, 52'h100, 1'b1);
    mem[1] = ent(16'h0002, 52'h100, 1'b1);
    mem[2] = ent(16'h0001, 52'h200, 1'b0);
    mem[3] = ent(16'h0003, 52'hABC, 1'b1);
    mem[4] = ent(16'h0001, 52'h200, 1'b1);
    mem[5] = ent(16'h0003, 52'hABC, 1'b1);
    mem[6] = '0;
    mem[7] = ent(16'h0007, 52'hF_FFFF_FFFF_FFFF, 1'b1);

    // R10 reset state
    #1;
    check(ready_o === 1'b1 && done_o === 1'b0 && rd_en_o === 1'b0, "R10 in reset",
          64'({ready_o, done_o, rd_en_o}), 64'h4);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(pa_o === '0 && hit_o === 1'b0 && fault_o === 1'b0, "R10 after reset",
          64'({pa_o, hit_o, fault_o}), 64'd0);

    for (int v = 0; v < NV; v++)
      walk(VECS[v].pid, VECS[v].vpn, VECS[v].off, VECS[v].hit, int'(VECS[v].pfn), 1'b0);

    // R1: request held with other values during a walk must not alter it
    walk(16'h0001, 52'h100, 12'h010, 1'b1, 0, 1'b1);
    walk(16'h0002, 52'h100, 12'h020, 1'b1, 1, 1'b1);

    // R10: reset mid walk
    req_valid_i = 1'b1;
    req_pid_i   = 16'h0009;
    req_va_i    = {52'h100, 12'h0};
    @(posedge clk);
    @(negedge clk);
    req_valid_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b0;
    #1;
    check(ready_o === 1'b1 && rd_en_o === 1'b0 && done_o === 1'b0 && pa_o === '0,
          "R10 abort walk", 64'({ready_o, rd_en_o, done_o, pa_o}), 64'(1) << (PA_W + 2));
    @(negedge clk);
    rst_ni = 1'b1;
    last_pa = '0;
    @(negedge clk);
    repeat (FRAMES + 2) begin
      @(negedge clk);
      check(done_o === 1'b0, "R10 aborted walk never completes", 64'(done_o), 64'd0);
    end
    walk(16'h0003, 52'hABC, 12'hABC, 1'b1, 3, 1'b0);

    finish_run();
  end
endmodule